// File: doc/BRIEF.md
# Dual-Bank GPIO Port with Polarity Control

This block provides sixteen general-purpose pins, arranged as two banks of eight. Each pin has three register bits: direction, data and polarity. A polarity bit of 1 flips the pin's value in both directions. It inverts the stored data on its way out to the pad, and it inverts the sampled pad level on its way back to the reader. Pad inputs pass through a two-flop synchronizer before anything else sees them.

Software reaches the registers by two routes. The first is an indexed configuration port. The second is a 4-byte I/O window whose base address is held in two configuration bytes. The window carries only the direction and data registers of each bank. A 3-bit activate field decides which banks are live: bit 0 turns on both banks, and when bit 0 is clear, bits 1 and 2 turn on bank 1 and bank 2 separately. Pin 0 of bank 1 is a push-pull driver. Every other pin is open-drain, so it can only pull low.

Both access ports are plain strobed register ports with no back-pressure. A write completes on the clock edge where its strobe is high. Read data is combinational from the presented index or address.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, both direction registers read FFh. The data, polarity, activate and base registers read 00h. All pins have output enable low.
- R2: A direction bit of 1 makes the pin an input, with output enable low. A direction bit of 0 makes it an output while its bank is enabled.
- R3: An enabled output pin drives the value v = data XOR polarity. Pin 0 of bank 1 (pin_out[0]) is push-pull: output enable 1 and pin_out = v. Every other pin is open-drain: pin_out = 0 and output enable = NOT v.
- R4: Reading a data register returns, for each input pin, the pad level XOR its polarity bit. A pad change becomes visible in the read value after the second rising clock edge.
- R5: Reading a data register returns, for each output pin, the stored data bit.
- R6: The configuration index map is as follows. 30h holds activate, with bits 2:0 stored and upper bits reading 0. 60h and 61h hold the base high and low bytes. F0h, F1h and F2h hold bank 1 direction, data and polarity. F3h, F4h and F5h hold the same for bank 2. Any other index reads 00h, and writes to it change nothing.
- R7: The I/O window base is {60h,61h} with its low two bits ignored. The window is live only when the aligned base lies between 0100h and 0FF8h inclusive. On a hit, offsets 0 to 3 select bank 1 direction, bank 1 data, bank 2 direction and bank 2 data. io_hit flags the hit.
- R8: I/O writes to an address outside a live window leave every register unchanged. io_rdata reads 00h on a miss.
- R9: Bank b (b = 1, 2) is enabled when activate bit 0 or activate bit b is 1.
- R10: A disabled bank drives no pin and reads its data register as 00h. Its registers still accept writes, and the written values take effect once the bank is enabled.
- R11: When a configuration write and a window write hit the same register in one cycle, the configuration value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| io_wr | input | 1 | I/O window write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (00h on a miss) |
| io_hit | output | 1 | io_addr falls in the live window |
| pin_in | input | 16 | Pad input levels, bank 2 in bits 15:8 |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |

## Verification
The bench checks the window at both ends of its legal range: 0100h and 0FF8h are live, while 00FCh and 0FFCh are not. A decoder with an off-by-one compare would then answer, or miss, at an edge base. It also checks that unaligned low base bits are ignored, and that an out-of-range window drops writes; a decoder that failed here would corrupt registers through a window that should be dead. Polarity is exercised on both paths at once, with mixed-direction banks, to catch a design that inverts only one way or forgets to skip output pins on readback. Further cases cover the two-edge synchronizer latency, every activate combination including a disabled bank whose data is later revealed, and a collision between the two write ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned NUM_BANKS  = 2;
  localparam int unsigned ADDR_W     = 16;
  localparam logic [7:0]  IDX_ACT    = 8'h30;
  localparam logic [7:0]  IDX_BASE_H = 8'h60;
  localparam logic [7:0]  IDX_BASE_L = 8'h61;
  localparam logic [7:0]  IDX_BANK0  = 8'hF0;
  localparam int unsigned REGS_PER_BANK = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int           W       = 8,
  parameter logic [W-1:0] PP_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         we_dir,
  input  logic [W-1:0] wd_dir,
  input  logic         we_dat,
  input  logic [W-1:0] wd_dat,
  input  logic         we_inv,
  input  logic [W-1:0] wd_inv,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] inv_q,
  output logic [W-1:0] dat_rd,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] dat_q;
  logic [W-1:0] drive_val;
  logic [W-1:0] rd_mix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      dat_q <= '0;
      inv_q <= '0;
    end else begin
      if (we_dir) dir_q <= wd_dir;
      if (we_dat) dat_q <= wd_dat;
      if (we_inv) inv_q <= wd_inv;
    end
  end

  assign drive_val = dat_q ^ inv_q;

  for (genvar i = 0; i < W; i++) begin : g_pad
    if (PP_MASK[i]) begin : g_pp
      assign pin_oe[i]  = enable & ~dir_q[i];
      assign pin_out[i] = enable & ~dir_q[i] & drive_val[i];
    end else begin : g_od
      assign pin_oe[i]  = enable & ~dir_q[i] & ~drive_val[i];
      assign pin_out[i] = 1'b0;
    end
  end

  // inputs read the synchronized pad through the polarity bit, outputs read storage
  assign rd_mix = (dir_q & (pin_sync ^ inv_q)) | (~dir_q & dat_q);
  assign dat_rd = enable ? rd_mix : '0;

  // R2
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);

  // R3
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~PP_MASK) == '0);

  // R10
  off_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (dat_rd == '0 && pin_oe == '0));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_io_window.sv
module gpio_io_window #(
  parameter int              AW     = 16,
  parameter logic [AW-1:0]   WIN_LO = 16'h0100,
  parameter logic [AW-1:0]   WIN_HI = 16'h0FF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [1:0]    offset
);
  logic [AW-1:0] base_al;
  logic          in_range;

  assign base_al  = {base[AW-1:2], 2'b00};
  assign in_range = (base_al >= WIN_LO) && (base_al <= WIN_HI);
  assign hit      = in_range && (addr[AW-1:2] == base[AW-1:2]);
  assign offset   = addr[1:0];

  // R7
  hit_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr >= WIN_LO && addr <= WIN_HI + AW'(3)));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int                         SYNC_STAGES = 2,
  parameter logic [15:0]                WIN_LO      = 16'h0100,
  parameter logic [15:0]                WIN_HI      = 16'h0FF8,
  parameter logic [2*gpio_pkg::REG_W-1:0] PP_MASK   = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        io_hit,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe
);
  import gpio_pkg::*;

  localparam int PW = REG_W;
  localparam int NB = NUM_BANKS;

  logic [2:0]    act_q;
  logic [7:0]    base_hi_q, base_lo_q;
  logic [NB*PW-1:0] pin_sync;
  logic [1:0]    io_off;

  logic [NB-1:0] cfg_dir_hit, cfg_dat_hit, cfg_inv_hit;
  logic [NB-1:0] io_dir_hit, io_dat_hit;
  logic [NB-1:0] bank_en;
  logic [PW-1:0] bank_dir [NB];
  logic [PW-1:0] bank_inv [NB];
  logic [PW-1:0] bank_rd  [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_ACT)    act_q     <= cfg_wdata[2:0];
      if (cfg_idx == IDX_BASE_H) base_hi_q <= cfg_wdata;
      if (cfg_idx == IDX_BASE_L) base_lo_q <= cfg_wdata;
    end
  end

  gpio_sync #(.W(NB*PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_io_window #(.AW(16), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .clk(clk), .rst_n(rst_n), .base({base_hi_q, base_lo_q}),
    .addr(io_addr), .hit(io_hit), .offset(io_off)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [7:0] IDX_B = IDX_BANK0 + 8'(REGS_PER_BANK * b);
    logic we_dir, we_dat, we_inv;
    logic [PW-1:0] wd_dir, wd_dat;

    assign cfg_dir_hit[b] = (cfg_idx == IDX_B);
    assign cfg_dat_hit[b] = (cfg_idx == IDX_B + 8'd1);
    assign cfg_inv_hit[b] = (cfg_idx == IDX_B + 8'd2);
    assign io_dir_hit[b]  = io_hit && (io_off == 2'(2 * b));
    assign io_dat_hit[b]  = io_hit && (io_off == 2'(2 * b + 1));
    assign bank_en[b]     = act_q[0] | act_q[b+1];

    assign we_dir = (cfg_wr & cfg_dir_hit[b]) | (io_wr & io_dir_hit[b]);
    assign we_dat = (cfg_wr & cfg_dat_hit[b]) | (io_wr & io_dat_hit[b]);
    assign we_inv = cfg_wr & cfg_inv_hit[b];
    // the configuration port wins a same-register collision
    assign wd_dir = (cfg_wr & cfg_dir_hit[b]) ? cfg_wdata : io_wdata;
    assign wd_dat = (cfg_wr & cfg_dat_hit[b]) ? cfg_wdata : io_wdata;

    gpio_bank #(.W(PW), .PP_MASK(PP_MASK[b*PW +: PW])) u_bank (
      .clk(clk), .rst_n(rst_n), .enable(bank_en[b]),
      .we_dir(we_dir), .wd_dir(wd_dir),
      .we_dat(we_dat), .wd_dat(wd_dat),
      .we_inv(we_inv), .wd_inv(cfg_wdata),
      .pin_sync(pin_sync[b*PW +: PW]),
      .dir_q(bank_dir[b]), .inv_q(bank_inv[b]), .dat_rd(bank_rd[b]),
      .pin_out(pin_out[b*PW +: PW]), .pin_oe(pin_oe[b*PW +: PW])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == IDX_ACT)    cfg_rdata = {5'b0, act_q};
    if (cfg_idx == IDX_BASE_H) cfg_rdata = base_hi_q;
    if (cfg_idx == IDX_BASE_L) cfg_rdata = base_lo_q;
    for (int b = 0; b < NB; b++) begin
      if (cfg_dir_hit[b]) cfg_rdata = bank_dir[b];
      if (cfg_dat_hit[b]) cfg_rdata = bank_rd[b];
      if (cfg_inv_hit[b]) cfg_rdata = bank_inv[b];
    end
  end

  always_comb begin
    io_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (io_dir_hit[b]) io_rdata = bank_dir[b];
      if (io_dat_hit[b]) io_rdata = bank_rd[b];
    end
  end

  // R8
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 8'h00);
endmodule

// File: tb/test_gpio_dual_bank.sv
module test_gpio_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_idx, cfg_wdata, cfg_rdata;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_hit;
  logic [15:0] pin_in, pin_out, pin_oe;

  always #2 clk = ~clk;

  gpio_dual_bank i_gpio_dual_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference
  logic [7:0]  m_dir [2];
  logic [7:0]  m_dat [2];
  logic [7:0]  m_inv [2];
  logic [2:0]  m_act;
  logic [7:0]  m_hi, m_lo;
  logic [15:0] m_s1, m_s2;

  int    errors = 0;
  int    checks = 0;
  string req_tag = "R1";
  bit    finished = 0;

  function automatic bit m_en(int b);
    return m_act[0] | m_act[b+1];
  endfunction

  function automatic bit m_hit();
    int base;
    base = {m_hi, m_lo};
    base = base - (base % 4);
    return (base >= 'h100) && (base <= 'hFF8) && (int'(io_addr) / 4 == base / 4);
  endfunction

  function automatic logic [7:0] m_read(int b);
    logic [7:0] r;
    r = 8'h00;
    if (!m_en(b)) return r;
    for (int i = 0; i < 8; i++)
      r[i] = m_dir[b][i] ? (m_s2[b*8+i] ^ m_inv[b][i]) : m_dat[b][i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir[0] <= 8'hFF; m_dir[1] <= 8'hFF;
      m_dat[0] <= 8'h00; m_dat[1] <= 8'h00;
      m_inv[0] <= 8'h00; m_inv[1] <= 8'h00;
      m_act <= 3'd0; m_hi <= 8'h00; m_lo <= 8'h00;
      m_s1 <= 16'h0; m_s2 <= 16'h0;
    end else begin
      if (io_wr && m_hit()) begin
        case (io_addr[1:0])
          2'd0: m_dir[0] <= io_wdata;
          2'd1: m_dat[0] <= io_wdata;
          2'd2: m_dir[1] <= io_wdata;
          default: m_dat[1] <= io_wdata;
        endcase
      end
      if (cfg_wr) begin
        case (cfg_idx)
          8'h30: m_act <= cfg_wdata[2:0];
          8'h60: m_hi <= cfg_wdata;
          8'h61: m_lo <= cfg_wdata;
          8'hF0: m_dir[0] <= cfg_wdata;
          8'hF1: m_dat[0] <= cfg_wdata;
          8'hF2: m_inv[0] <= cfg_wdata;
          8'hF3: m_dir[1] <= cfg_wdata;
          8'hF4: m_dat[1] <= cfg_wdata;
          8'hF5: m_inv[1] <= cfg_wdata;
          default: ;
        endcase
      end
      m_s1 <= pin_in;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] eo, ee;
    logic [7:0]  ecfg, eio;
    bit          eh;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) begin
        logic v;
        v = m_dat[b][i] ^ m_inv[b][i];
        if (!m_en(b) || m_dir[b][i]) begin
          eo[b*8+i] = 1'b0; ee[b*8+i] = 1'b0;
        end else if (b == 0 && i == 0) begin
          eo[b*8+i] = v; ee[b*8+i] = 1'b1;
        end else begin
          eo[b*8+i] = 1'b0; ee[b*8+i] = ~v;
        end
      end
    end
    case (cfg_idx)
      8'h30: ecfg = {5'b0, m_act};
      8'h60: ecfg = m_hi;
      8'h61: ecfg = m_lo;
      8'hF0: ecfg = m_dir[0];
      8'hF1: ecfg = m_read(0);
      8'hF2: ecfg = m_inv[0];
      8'hF3: ecfg = m_dir[1];
      8'hF4: ecfg = m_read(1);
      8'hF5: ecfg = m_inv[1];
      default: ecfg = 8'h00;
    endcase
    eh = m_hit();
    eio = 8'h00;
    if (eh) begin
      case (io_addr[1:0])
        2'd0: eio = m_dir[0];
        2'd1: eio = m_read(0);
        2'd2: eio = m_dir[1];
        default: eio = m_read(1);
      endcase
    end
    chk("pin_out", pin_out, eo);
    chk("pin_oe", pin_oe, ee);
    chk("cfg_rdata", {8'h00, cfg_rdata}, {8'h00, ecfg});
    chk("io_rdata", {8'h00, io_rdata}, {8'h00, eio});
    chk("io_hit", {15'h0, io_hit}, {15'h0, eh});
  endtask

  always @(negedge clk) begin
    #1;
    if (!finished) compare();
  end

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] idx);
    @(negedge clk); cfg_idx = idx;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] val);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = val;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_peek(input logic [15:0] a);
    @(negedge clk); io_addr = a;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = 8'h00; cfg_wdata = 8'h00;
    io_wr = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00; pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    req_tag = "R1";
    peek(8'hF0); peek(8'hF3); peek(8'hF1); peek(8'h30); peek(8'h60); peek(8'hF5);

    // R9 master activate
    req_tag = "R9";
    cfg_write(8'h30, 8'h01); peek(8'h30);

    // R2 / R3 output drive with polarity
    req_tag = "R2";
    cfg_write(8'hF0, 8'h00); cfg_write(8'hF3, 8'h0F);
    req_tag = "R3";
    cfg_write(8'hF1, 8'hA5); cfg_write(8'hF2, 8'h0F);
    cfg_write(8'hF4, 8'h3C); cfg_write(8'hF5, 8'hFF);
    cfg_write(8'hF1, 8'h01); cfg_write(8'hF2, 8'h00);
    cfg_write(8'hF1, 8'h00); cfg_write(8'hF2, 8'h01);

    // R5 output readback
    req_tag = "R5";
    peek(8'hF1); peek(8'hF4);

    // R4 input readback through synchronizer and polarity
    req_tag = "R4";
    cfg_write(8'hF0, 8'hF0); cfg_write(8'hF2, 8'h33);
    peek(8'hF1);
    @(negedge clk); pin_in = 16'h5A3C;
    repeat (3) @(negedge clk);
    pin_in = 16'hA5C3;
    peek(8'hF4); repeat (3) @(negedge clk);
    pin_in = 16'hFFFF; repeat (3) @(negedge clk);

    // R9 per-bank enables
    req_tag = "R9";
    cfg_write(8'h30, 8'h02); peek(8'hF4);
    cfg_write(8'h30, 8'h04); peek(8'hF1);
    cfg_write(8'h30, 8'h06); peek(8'hF4);
    cfg_write(8'h30, 8'hF8); peek(8'h30);

    // R10 disabled banks still take writes
    req_tag = "R10";
    cfg_write(8'hF0, 8'h00); cfg_write(8'hF1, 8'h96);
    cfg_write(8'hF3, 8'h00); cfg_write(8'hF4, 8'h69);
    peek(8'hF1); peek(8'hF4);
    cfg_write(8'h30, 8'h01); peek(8'hF1); peek(8'hF4);

    // R6 unused indexes
    req_tag = "R6";
    cfg_write(8'h45, 8'hFF); peek(8'h45);
    cfg_write(8'hF6, 8'hFF); peek(8'hF6); peek(8'h31); peek(8'hF2);

    // R7 window, unaligned base bits ignored
    req_tag = "R7";
    cfg_write(8'h60, 8'h03); cfg_write(8'h61, 8'h47);
    io_write(16'h0344, 8'hC3); io_write(16'h0345, 8'h81);
    io_write(16'h0346, 8'h0F); io_write(16'h0347, 8'hF0);
    io_peek(16'h0344); io_peek(16'h0345); io_peek(16'h0346); io_peek(16'h0347);
    io_peek(16'h0348); io_peek(16'h0343);
    cfg_write(8'h61, 8'h00); cfg_write(8'h60, 8'h01);
    io_write(16'h0100, 8'h00); io_peek(16'h0101);
    cfg_write(8'h60, 8'h0F); cfg_write(8'h61, 8'hF8);
    io_write(16'h0FF9, 8'h5A); io_peek(16'h0FF9);

    // R8 out-of-range windows drop writes
    req_tag = "R8";
    cfg_write(8'h61, 8'hFC);
    io_write(16'h0FFC, 8'h00); io_write(16'h0FFD, 8'h00); peek(8'hF1);
    cfg_write(8'h60, 8'h00);
    io_write(16'h00FC, 8'hFF); io_write(16'h00FE, 8'hFF); peek(8'hF3);

    // R11 collision
    req_tag = "R11";
    cfg_write(8'h60, 8'h02); cfg_write(8'h61, 8'h00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 8'hF0; cfg_wdata = 8'h3C;
    io_wr = 1'b1; io_addr = 16'h0200; io_wdata = 8'hC3;
    @(negedge clk); cfg_wr = 1'b0; io_wr = 1'b0;
    peek(8'hF0);

    // mixed traffic
    req_tag = "R3";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      begin
        int sel;
        sel = $urandom % 11;
        case (sel)
          0: cfg_idx = 8'h30; 1: cfg_idx = 8'h60; 2: cfg_idx = 8'h61;
          3: cfg_idx = 8'hF0; 4: cfg_idx = 8'hF1; 5: cfg_idx = 8'hF2;
          6: cfg_idx = 8'hF3; 7: cfg_idx = 8'hF4; 8: cfg_idx = 8'hF5;
          default: cfg_idx = 8'h52;
        endcase
        cfg_wr = (($urandom % 4) == 0) && (sel != 1);
        cfg_wdata = 8'($urandom);
        io_wr = ($urandom % 3) == 0;
        io_addr = (($urandom % 5) == 0) ? 16'($urandom) : ({m_hi, m_lo} & 16'hFFFC) + 16'($urandom % 4);
        io_wdata = 8'($urandom);
        pin_in = 16'($urandom);
      end
    end
    @(negedge clk); cfg_wr = 1'b0; io_wr = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule